// File: doc/BRIEF.md
# Streaming Sliding-Window Generator

This block turns a raster-ordered stream of feature-map samples, one per clock, into a square P×P neighbourhood for a convolution datapath that follows it. The stream describes images W samples wide and H rows tall, sent back to back with no gap marker. The block keeps P chained rows of shift registers. Each row has a long delay part followed by a short window part, and the window parts together form the P×P matrix. The whole matrix is presented in parallel every cycle.

A flag marks the cycles in which the presented matrix is a real neighbourhood. That means the initial fill is complete and no window row wraps across an image edge or a frame edge. Because of the chain's shape, the newest W−P samples are still in the delay parts, so each window's bottom-right sample (its anchor) is the sample accepted W−P cycles earlier. The last windows of a frame therefore come out while the first samples of the following frame are accepted. An upstream source can pause the stream at any cycle. A pause freezes everything, and the flag stays low while paused.

Top module: `sliding_window_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `win_valid` is low after that edge. Reset restarts sample counting, so the fill interval of R4 begins again.
- R2: In a cycle with `in_valid` low, no sample is taken. After that edge `win_data` is unchanged and `win_valid` is low.
- R3: After accepting sample k (counted from 0 since reset), let the anchor be a = k−(W−P). When `win_valid` is high, the element at row r, column c sits at bits [(r·P+c)·DW +: DW] and holds sample a−(P−1−r)·W−(P−1−c). Row 0 is the oldest image row and column 0 is the leftmost.
- R4: `win_valid` is first high right after the W·P-th accepted sample since reset, and never earlier.
- R5: Let the anchor column be a mod W and the anchor row be (a div W) mod H. After an accepted sample, `win_valid` is high exactly when a ≥ 0, the anchor column ≥ P−1 and the anchor row ≥ P−1.
- R6: On every accepted sample, the matrix moves by one column. The new element in column c equals the old element in column c+1 of the same row.
- R7: One W×H frame followed by W−P further samples gives exactly (W−P+1)·(H−P+1) valid windows. With the defaults this is 121.
- R8: When frames are streamed back to back, a window anchored in the first P−1 rows of a frame is never valid. Three frames followed by W−P samples give three times the R7 count.
- R9: Pauses inserted anywhere in the stream do not change the number or the content of the valid windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is offered this cycle |
| in_data | input | DW | Sample value |
| win_valid | output | 1 | `win_data` is a complete in-image window |
| win_data | output | P·P·DW | Window matrix, element (r,c) at (r·P+c)·DW |

## Verification
A wrong anchor column or row counter shows up as a valid flag in the wrong cycle. It is seen on the very next edge after the first affected sample, or at the latest when the next row begins. A broken link between chain rows corrupts the top rows of the matrix. This appears in the first valid window after the break, at most W·P samples later. A chain that shifts during a pause shows up in the pause cycle itself as a changed `win_data`. The bench models every window from the sample index alone, so it compares each matrix element on every valid cycle.

// File: rtl/swin_pkg.sv
package swin_pkg;

  // flat slot index of element (row, col) in a side x side matrix
  function automatic int unsigned swin_slot(input int unsigned row,
                                            input int unsigned col,
                                            input int unsigned side);
    return row * side + col;
  endfunction

  // an anchor at (col,row) closes a complete window inside the image
  function automatic logic swin_anchor_ok(input int unsigned col,
                                          input int unsigned row,
                                          input int unsigned side);
    return ((col + 1) >= side) && ((row + 1) >= side);
  endfunction

endpackage

// File: rtl/swin_chain_row.sv
module swin_chain_row #(
  parameter int DW = 16,
  parameter int W  = 13,
  parameter int P  = 3
) (
  input  logic            clk,
  input  logic            adv,
  input  logic [DW-1:0]   feed_i,
  output logic [P*DW-1:0] taps_o
);
  localparam int DLY = W - P;

  logic [DW-1:0] win_q [P];
  logic [DW-1:0] win_feed;

  generate
    if (DLY > 0) begin : g_dly
      logic [DW-1:0] dly_q [DLY];
      always_ff @(posedge clk) begin
        if (adv) begin
          dly_q[0] <= feed_i;
          for (int k = 1; k < DLY; k++) dly_q[k] <= dly_q[k-1];
        end
      end
      assign win_feed = dly_q[DLY-1];
    end else begin : g_nodly
      assign win_feed = feed_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (adv) begin
      win_q[0] <= win_feed;
      for (int k = 1; k < P; k++) win_q[k] <= win_q[k-1];
    end
  end

  generate
    for (genvar c = 0; c < P; c++) begin : g_tap
      assign taps_o[c*DW +: DW] = win_q[c];
    end
  endgenerate
endmodule

// File: rtl/swin_anchor_trk.sv
module swin_anchor_trk
  import swin_pkg::*;
#(
  parameter int W = 13,
  parameter int H = 13,
  parameter int P = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  output logic                 live_o,
  output logic [$clog2(W)-1:0] acol_o,
  output logic [$clog2(H)-1:0] arow_o,
  output logic                 ok_q_o
);
  localparam int LEAD = W - P;
  localparam int LW   = (LEAD > 0) ? $clog2(LEAD + 1) : 1;
  localparam int CW   = $clog2(W);
  localparam int RW   = $clog2(H);

  logic [LW-1:0] lead_q;
  logic [CW-1:0] acol_q;
  logic [RW-1:0] arow_q;
  logic          ok_q;
  logic          live;
  logic          ok_now;

  assign live   = (lead_q == LW'(LEAD));
  assign ok_now = adv && live && swin_anchor_ok(32'(acol_q), 32'(arow_q), P);

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_q <= '0;
      acol_q <= '0;
      arow_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      ok_q <= ok_now;
      if (adv) begin
        if (!live) begin
          lead_q <= lead_q + 1'b1;
        end else if (acol_q == CW'(W - 1)) begin
          acol_q <= '0;
          arow_q <= (arow_q == RW'(H - 1)) ? '0 : arow_q + 1'b1;
        end else begin
          acol_q <= acol_q + 1'b1;
        end
      end
    end
  end

  assign live_o = live;
  assign acol_o = acol_q;
  assign arow_o = arow_q;
  assign ok_q_o = ok_q;
endmodule

// File: rtl/sliding_window_gen.sv
module sliding_window_gen
  import swin_pkg::*;
#(
  parameter int DW = 16,
  parameter int W  = 13,
  parameter int H  = 13,
  parameter int P  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              win_valid,
  output logic [P*P*DW-1:0] win_data
);
  localparam int CW = $clog2(W);
  localparam int RW = $clog2(H);

  // named events for the bound checker
  logic          accept;
  logic          anchor_live;
  logic [CW-1:0] acol;
  logic [RW-1:0] arow;

  logic [P*DW-1:0] row_taps [P];
  logic [DW-1:0]   row_feed [P];

  assign accept = in_valid;

  generate
    for (genvar r = 0; r < P; r++) begin : g_row
      if (r == 0) begin : g_head
        assign row_feed[r] = in_data;
      end else begin : g_link
        assign row_feed[r] = row_taps[r-1][(P-1)*DW +: DW];
      end
      swin_chain_row #(.DW(DW), .W(W), .P(P)) row_i (
        .clk    (clk),
        .adv    (accept),
        .feed_i (row_feed[r]),
        .taps_o (row_taps[r])
      );
    end
  endgenerate

  // chain row 0 / column 0 hold the anchor; flip both axes for output
  generate
    for (genvar r = 0; r < P; r++) begin : g_or
      for (genvar c = 0; c < P; c++) begin : g_oc
        assign win_data[swin_slot(r, c, P)*DW +: DW] =
          row_taps[P-1-r][(P-1-c)*DW +: DW];
      end
    end
  endgenerate

  swin_anchor_trk #(.W(W), .H(H), .P(P)) trk_i (
    .clk    (clk),
    .rst    (rst),
    .adv    (accept),
    .live_o (anchor_live),
    .acol_o (acol),
    .arow_o (arow),
    .ok_q_o (win_valid)
  );
endmodule

// File: rtl/sliding_window_gen_chk.sv
module sliding_window_gen_chk #(
  parameter int DW = 16,
  parameter int W  = 13,
  parameter int H  = 13,
  parameter int P  = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 win_valid,
  input logic [P*P*DW-1:0]    win_data,
  input logic                 anchor_live,
  input logic [$clog2(W)-1:0] acol,
  input logic [$clog2(H)-1:0] arow
);
  localparam int FILL = W * P;
  localparam int FW   = $clog2(FILL + 1);

  logic [FW-1:0] fill_cnt;
  always_ff @(posedge clk) begin
    if (rst) fill_cnt <= '0;
    else if (in_valid && fill_cnt != FW'(FILL)) fill_cnt <= fill_cnt + 1'b1;
  end

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !win_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(win_data)); // R2
  AST_FILL_FIRST: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> fill_cnt == FW'(FILL)); // R4
  AST_ANCHOR_LIVE: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> $past(anchor_live)); // R5
  AST_ANCHOR_COL: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> int'($past(acol)) >= P - 1); // R5
  AST_ANCHOR_ROW: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> int'($past(arow)) >= P - 1); // R8
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(acol) < W) && (int'(arow) < H)); // R5
  AST_STRIDE_ONE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> win_data[0 +: DW] == $past(win_data[DW +: DW])); // R6
endmodule

bind sliding_window_gen sliding_window_gen_chk #(
  .DW(DW), .W(W), .H(H), .P(P)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .win_valid   (win_valid),
  .win_data    (win_data),
  .anchor_live (anchor_live),
  .acol        (acol),
  .arow        (arow)
);

// File: tb/sliding_window_gen_tb_top.sv
`timescale 1ns/1ps
module sliding_window_gen_tb_top;
  localparam int DW   = 16;
  localparam int W    = 13;
  localparam int H    = 13;
  localparam int P    = 3;
  localparam int LEAD = W - P;
  localparam int NWIN = (W - P + 1) * (H - P + 1);
  localparam int VW   = P * P * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          win_valid;
  logic [VW-1:0] win_data;

  int n_chk = 0;
  int n_bad = 0;
  int n_acc, n_win, first_k, bad_top;
  logic          last_v;
  int            last_m;
  logic [VW-1:0] prev_win;

  always #4 clk = ~clk;

  sliding_window_gen #(.DW(DW), .W(W), .H(H), .P(P)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .win_valid(win_valid), .win_data(win_data)
  );

  function automatic logic [DW-1:0] pix(input int m);
    return DW'(m * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [VW-1:0] act, input logic [VW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic do_reset(input bit offer);
    @(negedge clk);
    rst = 1'b1;
    in_valid = offer;
    in_data = DW'(16'hA5A5);
    repeat (2) begin
      @(posedge clk); @(negedge clk);
      chk(win_valid === 1'b0, "R1 valid low in reset", VW'(win_valid), '0);
    end
    rst = 1'b0;
    in_valid = 1'b0;
    n_acc = 0; n_win = 0; first_k = -1; bad_top = 0;
    last_v = 1'b0; last_m = -1;
    prev_win = win_data;
  endtask

  // drive at negedge, let one edge pass, check at the next negedge
  task automatic step(input bit v);
    int k, m, xm, ym;
    bit exp_v;
    logic [VW-1:0] expw;
    k = n_acc;
    in_valid = v;
    in_data = v ? pix(k) : DW'(16'hBEEF);
    @(posedge clk); @(negedge clk);
    if (v) begin
      n_acc++;
      m = k - LEAD;
      xm = (m >= 0) ? m % W : 0;
      ym = (m >= 0) ? (m / W) % H : 0;
      exp_v = (m >= 0) && (xm >= P - 1) && (ym >= P - 1);
      chk(win_valid === exp_v, "R5 valid flag", VW'(win_valid), VW'(exp_v));
      if (win_valid === 1'b1 && (m < 0 || ym < P - 1)) bad_top++;
      if (win_valid === 1'b1) begin
        n_win++;
        if (first_k < 0) first_k = k;
      end
      if (exp_v) begin
        for (int r = 0; r < P; r++)
          for (int c = 0; c < P; c++)
            expw[(r*P+c)*DW +: DW] = pix(m - (P-1-r)*W - (P-1-c));
        chk(win_data === expw, "R3 window content", win_data, expw);
        if (last_v && last_m == m - 1) begin
          for (int r = 0; r < P; r++)
            for (int c = 0; c < P - 1; c++)
              chk(win_data[(r*P+c)*DW +: DW] === prev_win[(r*P+c+1)*DW +: DW],
                  "R6 column step", VW'(win_data[(r*P+c)*DW +: DW]),
                  VW'(prev_win[(r*P+c+1)*DW +: DW]));
        end
      end
      last_v = exp_v;
      last_m = m;
    end else begin
      chk(win_valid === 1'b0, "R2 valid low while idle", VW'(win_valid), '0);
      chk(win_data === prev_win, "R2 window held while idle", win_data, prev_win);
    end
    prev_win = win_data;
  endtask

  task automatic t_fill_and_count();
    do_reset(1'b0);
    for (int i = 0; i < W*H + LEAD; i++) step(1'b1);
    chk(first_k == W*P - 1, "R4 first valid sample", VW'(first_k), VW'(W*P-1));
    chk(n_win == NWIN, "R7 window count", VW'(n_win), VW'(NWIN));
  endtask

  task automatic t_stalls();
    do_reset(1'b0);
    step(1'b0);
    for (int i = 0; i < W*H + LEAD; i++) begin
      step(1'b1);
      if (i % 4 == 3) step(1'b0);
      if (i % 11 == 5) begin step(1'b0); step(1'b0); end
    end
    chk(n_win == NWIN, "R9 count with pauses", VW'(n_win), VW'(NWIN));
    chk(first_k == W*P - 1, "R4 first valid with pauses", VW'(first_k), VW'(W*P-1));
  endtask

  task automatic t_frames();
    do_reset(1'b0);
    for (int i = 0; i < 3*W*H + LEAD; i++) step(1'b1);
    chk(n_win == 3*NWIN, "R8 three-frame count", VW'(n_win), VW'(3*NWIN));
    chk(bad_top == 0, "R8 no window across frame top", VW'(bad_top), '0);
  endtask

  task automatic t_mid_reset();
    do_reset(1'b0);
    for (int i = 0; i < 40; i++) step(1'b1);
    do_reset(1'b1);
    for (int i = 0; i < W*P - 1; i++) step(1'b1);
    chk(n_win == 0, "R1 refill after reset", VW'(n_win), '0);
    step(1'b1);
    chk(n_win == 1, "R4 first window after reset", VW'(n_win), VW'(1));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    do_reset(1'b0);
    t_fill_and_count();
    t_stalls();
    t_frames();
    t_mid_reset();
    summary();
    $finish;
  end
endmodule